// File: doc/BRIEF.md
# Latched Serial-to-Parallel Output Expander

This block turns a three-wire serial stream into a wide set of parallel outputs. A controller puts one bit on the serial data input and pulses the shift strobe. The bit enters stage 0 of an internal shift chain, and every stored bit moves one stage toward the top. After a whole word has been shifted in, a pulse on the latch strobe copies the complete chain into a separate storage register. That register drives the parallel outputs. The outputs therefore jump from one complete word to the next and never show a partial word.

Both strobes and the serial data are asynchronous to the system clock. All three pass through the same synchronizer depth, so each data bit arrives aligned with its strobe. After the synchronizer, the design acts on the rising edge of each strobe.

Other controls:
- An active-low clear empties the shift chain.
- An active-low output enable gates the parallel outputs to zero and reports its state on a separate flag.
- A cascade output presents the top stage of the chain. It can feed the serial input of a further expander that shares both strobes.

Top module: `latched_sipo_expander`

## Requirements
- R1: A rising edge on `shift_stb` (with `ser_in` held stable across the pulse) shifts the chain by one place: `ser_in` enters stage 0 and stage i moves to stage i+1. The change takes effect within SYNC_STAGES+1 clock cycles of the edge.
- R2: A rising edge on `latch_stb` copies every stage of the chain into the storage register in the same cycle.
- R3: `par_out` changes only because of a latch edge, an output-enable change or reset. Shifting alone never changes it.
- R4: When `oe_n` is 1, `par_out` is all zero and `out_en` is 0. When `oe_n` is 0, `par_out` equals the storage register and `out_en` is 1.
- R5: While `clr_n` is 0, the shift chain is cleared on each clock, and clear takes priority over a shift edge.
- R6: `cascade_out` always equals the top stage (bit WIDTH-1) of the shift chain.
- R7: Shifting a word MSB first, followed by a latch, places word bit k on `par_out[k]`. For example, 0x55 drives outputs 0, 2, 4 and 6 high.
- R8: Clear leaves the storage register unchanged. The outputs keep their value until the next latch edge.
- R9: When a shift edge and a latch edge fall in the same clock cycle, the storage register receives the chain contents from before that shift.
- R10: Only rising edges act. A strobe held high for many cycles causes one shift or one latch.
- R11: A low `rst_n` at a clock edge clears the shift chain, the storage register and the synchronizers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_in | input | 1 | Serial data bit |
| shift_stb | input | 1 | Shift strobe, rising edge acts |
| latch_stb | input | 1 | Latch strobe, rising edge acts |
| clr_n | input | 1 | Shift chain clear, active low |
| oe_n | input | 1 | Output enable, active low |
| par_out | output | WIDTH | Parallel outputs (zero when disabled) |
| out_en | output | 1 | High while outputs are enabled |
| cascade_out | output | 1 | Top chain stage, for chaining |

## Verification
The bench builds the block with its default WIDTH of 8 and SYNC_STAGES of 2. At that size every one of the 256 possible words can be shifted in MSB first and latched. The bench checks the cascade output after each bit and checks after each bit that the parallel outputs still show the previous word. With two synchronizer stages the strobe pulses stay short, so the full sweep and the directed cases for clear, output gating, held strobes, coincident edges and mid-run reset fit comfortably in the run.

// File: rtl/latched_sipo_expander.sv
module latched_sipo_expander #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_in,
  input  logic             shift_stb,
  input  logic             latch_stb,
  input  logic             clr_n,
  input  logic             oe_n,
  output logic [WIDTH-1:0] par_out,
  output logic             out_en,
  output logic             cascade_out
);

  localparam int TOP = WIDTH - 1;
  localparam int SL  = SYNC_STAGES - 1;

  logic [SL:0]    shf_pipe, lat_pipe, dat_pipe;
  logic           shf_last, lat_last;
  logic           shf_edge, lat_edge;
  logic [TOP:0]   chain, store;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shf_pipe <= '0;
      lat_pipe <= '0;
      dat_pipe <= '0;
      shf_last <= 1'b0;
      lat_last <= 1'b0;
    end else begin
      shf_pipe <= {shf_pipe[SL-1:0], shift_stb};
      lat_pipe <= {lat_pipe[SL-1:0], latch_stb};
      dat_pipe <= {dat_pipe[SL-1:0], ser_in};
      shf_last <= shf_pipe[SL];
      lat_last <= lat_pipe[SL];
    end
  end

  assign shf_edge = shf_pipe[SL] & ~shf_last;
  assign lat_edge = lat_pipe[SL] & ~lat_last;

  always_ff @(posedge clk) begin
    if (!rst_n)        chain <= '0;
    else if (!clr_n)   chain <= '0;
    else if (shf_edge) chain <= {chain[TOP-1:0], dat_pipe[SL]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        store <= '0;
    else if (lat_edge) store <= chain;
  end

  assign out_en      = ~oe_n;
  assign par_out     = oe_n ? '0 : store;
  assign cascade_out = chain[TOP];

endmodule

// File: rtl/latched_sipo_expander_props.sv
module latched_sipo_expander_props #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_n,
  input logic             oe_n,
  input logic             shf_edge,
  input logic             lat_edge,
  input logic             ser_bit,
  input logic [WIDTH-1:0] chain,
  input logic [WIDTH-1:0] store,
  input logic [WIDTH-1:0] par_out,
  input logic             out_en,
  input logic             cascade_out
);

  a_r1_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
    (shf_edge && clr_n) |=> chain == {$past(chain[WIDTH-2:0]), $past(ser_bit)});

  a_r2_latch_copy: assert property (@(posedge clk) disable iff (!rst_n)
    lat_edge |=> store == $past(chain));

  a_r3_store_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_edge |=> $stable(store));

  a_r4_gated_zero: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (par_out == '0 && !out_en));

  a_r4_enabled_view: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (par_out == store && out_en));

  a_r5_clear_chain: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> chain == '0);

  a_r6_cascade_top: assert property (@(posedge clk) disable iff (!rst_n)
    cascade_out == chain[WIDTH-1]);

endmodule

bind latched_sipo_expander latched_sipo_expander_props #(
  .WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)
) u_props (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .oe_n(oe_n),
  .shf_edge(shf_edge), .lat_edge(lat_edge), .ser_bit(dat_pipe[SYNC_STAGES-1]),
  .chain(chain), .store(store), .par_out(par_out), .out_en(out_en),
  .cascade_out(cascade_out)
);

// File: tb/test_latched_sipo_expander.sv
module test_latched_sipo_expander;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n, ser_in, shift_stb, latch_stb, clr_n, oe_n;
  logic [W-1:0] par_out;
  logic out_en, cascade_out;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] m_chain, m_store;

  always #2.5 clk = ~clk;

  latched_sipo_expander #(.WIDTH(W), .SYNC_STAGES(2)) i_latched_sipo_expander (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_stb(shift_stb),
    .latch_stb(latch_stb), .clr_n(clr_n), .oe_n(oe_n), .par_out(par_out),
    .out_en(out_en), .cascade_out(cascade_out));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    ser_in = b;
    @(negedge clk);
    shift_stb = 1'b1;
    idle(4);
    shift_stb = 1'b0;
    idle(4);
    m_chain = {m_chain[W-2:0], b};
  endtask

  task automatic latch_pulse();
    latch_stb = 1'b1;
    idle(4);
    latch_stb = 1'b0;
    idle(4);
    m_store = m_chain;
  endtask

  task automatic load_word(input logic [W-1:0] w, input bit watch);
    for (int k = W - 1; k >= 0; k--) begin
      shift_bit(w[k]);
      if (watch) begin
        chk("R6 cascade", {7'd0, cascade_out}, {7'd0, m_chain[W-1]});
        chk("R3 no change while shifting", par_out, m_store);
      end
    end
  endtask

  initial begin
    int wd;
    wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 190000) begin
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected<190000", wd);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; ser_in = 1'b0; shift_stb = 1'b0; latch_stb = 1'b0;
    clr_n = 1'b1; oe_n = 1'b0;
    m_chain = '0; m_store = '0;
    idle(4);
    rst_n = 1'b1;
    idle(2);
    chk("R11 reset outputs", par_out, '0);
    chk("R11 reset cascade", {7'd0, cascade_out}, '0);
    chk("R4 enabled flag", {7'd0, out_en}, 8'd1);

    for (int v = 0; v < 256; v++) begin
      load_word(v[W-1:0], 1'b1);
      latch_pulse();
      chk("R2 R7 latched word", par_out, v[W-1:0]);
    end

    load_word(8'h55, 1'b0);
    latch_pulse();
    chk("R7 0x55 on outputs 0,2,4,6", par_out, 8'b0101_0101);

    oe_n = 1'b1;
    #1;
    chk("R4 disabled zero", par_out, '0);
    chk("R4 disabled flag", {7'd0, out_en}, '0);
    oe_n = 1'b0;
    #1;
    chk("R4 re-enabled", par_out, 8'h55);

    load_word(8'hA7, 1'b0);
    @(negedge clk);
    clr_n = 1'b0;
    @(negedge clk);
    clr_n = 1'b1;
    m_chain = '0;
    chk("R5 clear cascade", {7'd0, cascade_out}, '0);
    chk("R8 clear keeps outputs", par_out, 8'h55);
    latch_pulse();
    chk("R5 cleared chain latched", par_out, '0);

    ser_in = 1'b1;
    @(negedge clk);
    clr_n = 1'b0;
    shift_stb = 1'b1;
    idle(6);
    clr_n = 1'b1;
    shift_stb = 1'b0;
    idle(4);
    latch_pulse();
    chk("R5 clear beats shift", par_out, '0);

    ser_in = 1'b1;
    @(negedge clk);
    shift_stb = 1'b1;
    idle(40);
    shift_stb = 1'b0;
    idle(4);
    m_chain = 8'h01;
    latch_stb = 1'b1;
    idle(40);
    latch_stb = 1'b0;
    idle(4);
    m_store = m_chain;
    chk("R10 held strobe shifts once", par_out, 8'h01);
    shift_bit(1'b0);
    chk("R10 held latch fired once", par_out, 8'h01);

    load_word(8'h5A, 1'b0);
    latch_pulse();
    load_word(8'h81, 1'b0);
    ser_in = 1'b0;
    @(negedge clk);
    shift_stb = 1'b1;
    latch_stb = 1'b1;
    idle(4);
    shift_stb = 1'b0;
    latch_stb = 1'b0;
    idle(4);
    chk("R9 coincident edges take pre-shift", par_out, 8'h81);
    m_chain = 8'h02;
    latch_pulse();
    chk("R9 shift still applied", par_out, 8'h02);
    chk("R1 shift of zero into 0x81", par_out, m_store);

    load_word(8'hC3, 1'b0);
    latch_pulse();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    chk("R11 mid-run reset outputs", par_out, '0);
    chk("R11 mid-run reset chain", {7'd0, cascade_out}, '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule